// File: doc/BRIEF.md
# Prioritised Interrupt Router

This block collects a set of level-sensitive interrupt sources and routes them to a small number of processor contexts. Software programs a priority for each source, an enable mask and a priority threshold for each context through a simple register bus. The block remembers which sources are pending. For each context it picks the best source that is pending, enabled and above threshold, and raises that context's interrupt request while such a source exists.

A context takes an interrupt by reading its claim register. The read returns the winning source number, or zero when nothing qualifies. In the same cycle it clears that source's pending bit and marks the source as in service for that context. While a source is in service its input cannot make it pending again. Service ends when the same context writes the source number back to the same register. Source numbers begin at 1. Number 0 always means "no interrupt".

The bus carries byte offsets. The two low address bits are ignored. A read returns data in the same cycle, and a write takes effect at the next clock edge. The default build has 31 sources, 2 contexts and 3-bit priorities.

Top module: `prio_irq_router`

## Requirements
- R1: After reset every priority, enable bit, threshold, pending bit and in-service mark is zero, every interrupt request is low, and every claim register reads 0.
- R2: Source N (1 to NUM_SRC) has a priority register at byte offset 4*N that holds the low PRIO_W bits of the written data and reads them back zero-extended. Offset 0 has no source behind it: it reads 0 and ignores writes.
- R3: Pending bits read as 32-bit words at 0x1000 + 4*k, where bit j of word k stands for source 32*k+j, and bit 0 of word 0 always reads 0. A source whose input is high at a clock edge and that is not in service is pending after that edge.
- R4: The enable mask of context C reads and writes as 32-bit words at 0x2000 + 0x80*C + 4*k, with the same bit layout as the pending words. Bit 0 of word 0 always reads 0.
- R5: The threshold of context C sits at 0x200000 + 0x1000*C and holds PRIO_W bits. A source is eligible for a context only when it is pending, enabled there, and its priority is strictly greater than that threshold, so priority 0 never interrupts.
- R6: The request output of context C is high in the same cycle, combinationally, exactly when at least one source is eligible for C.
- R7: A read of context C's claim register at 0x200004 + 0x1000*C returns the eligible source with the highest priority. Among equal priorities the smaller source number wins. The read returns 0 when no source is eligible.
- R8: A claim read that returns a nonzero source clears that source's pending bit at the same edge and puts the source in service. While it is in service its pending bit stays 0 whatever its input does.
- R9: Writing a source number to context C's claim register ends service of that source only if C claimed it. A write of a number that is not in service, was claimed by another context, or is out of range has no effect.
- R10: Every offset outside the registers listed above reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_SRC | Level interrupt inputs, bit N is source N |
| bus_addr | input | 24 | Byte offset of the register access |
| bus_re | input | 1 | Read strobe. A claim read has its side effect at the next edge |
| bus_we | input | 1 | Write strobe, takes effect at the next edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_re, zero otherwise |
| irq_o | output | NUM_CTX | Interrupt request, one bit per context |

## Verification
The bench goes after equal-priority ties. A design that scanned the sources in the wrong direction, or replaced the best candidate on equal priority, would hand out source 5 before source 3. It sets a priority exactly equal to the threshold, where an inclusive compare would raise the request. It holds a source high after it is claimed, where a gateway without an in-service mark would let the pending bit reappear at once. It also sends a completion from the wrong context or with a wrong number, which a design without per-source ownership would accept and reopen the source too early. Further directed checks cover the zero bit of the pending and enable words, offset 0 and reserved offsets. A long randomised run of writes, claims and completions against a bench-side model then catches ordering errors between claim, completion and new level inputs at the same edge.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

   localparam int ADDR_W = 24;
   localparam int DATA_W = 32;

   // Register regions, expressed in 32-bit word units
   localparam int PEND_WBASE   = 'h400;
   localparam int EN_WBASE     = 'h800;
   localparam int EN_WSTRIDE   = 32;
   localparam int CTX_WBASE    = 'h80000;
   localparam int CTX_WSTRIDE  = 1024;

   localparam int MAX_SRC      = 1023;
   localparam int MAX_CTX      = 3584;

   typedef enum logic [2:0] {
      RG_NONE,
      RG_PRIO,
      RG_PEND,
      RG_EN,
      RG_THR,
      RG_CLAIM
   } reg_kind_e;

endpackage

// File: rtl/irq_src_gate.sv
module irq_src_gate #(
   parameter int NUM_SRC = 31,
   parameter int NUM_CTX = 2,
   parameter int NPAD    = 32,
   parameter int IDW     = 5,
   parameter int CTXW    = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NUM_SRC:1] src_i,
   input  logic             clm_vld_i,
   input  logic [IDW-1:0]   clm_id_i,
   input  logic [CTXW-1:0]  clm_ctx_i,
   input  logic             cmp_vld_i,
   input  logic [IDW-1:0]   cmp_id_i,
   input  logic [CTXW-1:0]  cmp_ctx_i,
   output logic [NPAD-1:0]  pend_o,
   output logic [NPAD-1:0]  busy_o
);

   logic [NPAD-1:0] owner_ok;

   // Ownership tracking only exists when more than one context can claim
   if (NUM_CTX > 1) begin : g_owner
      for (genvar g = 0; g < NPAD; g++) begin : g_own_bit
         if (g >= 1 && g <= NUM_SRC) begin : g_live
            logic [CTXW-1:0] own_q;
            always_ff @(posedge clk) begin
               if (!rst_n)
                  own_q <= '0;
               else if (clm_vld_i && clm_id_i == IDW'(g))
                  own_q <= clm_ctx_i;
            end
            assign owner_ok[g] = (own_q == cmp_ctx_i);
         end else begin : g_dead
            assign owner_ok[g] = 1'b0;
         end
      end
   end else begin : g_single
      logic unused_ctx;
      assign unused_ctx = ^{clm_ctx_i, cmp_ctx_i};
      assign owner_ok   = '1;
   end

   for (genvar g = 0; g < NPAD; g++) begin : g_src
      if (g >= 1 && g <= NUM_SRC) begin : g_live
         logic pend_q;
         logic busy_q;
         logic take;
         logic done;

         assign take = clm_vld_i && (clm_id_i == IDW'(g));
         assign done = cmp_vld_i && (cmp_id_i == IDW'(g)) && busy_q && owner_ok[g];

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pend_q <= 1'b0;
               busy_q <= 1'b0;
            end else begin
               if (take)
                  pend_q <= 1'b0;
               else if (src_i[g] && !busy_q)
                  pend_q <= 1'b1;

               if (take)
                  busy_q <= 1'b1;
               else if (done)
                  busy_q <= 1'b0;
            end
         end

         assign pend_o[g] = pend_q;
         assign busy_o[g] = busy_q;
      end else begin : g_dead
         assign pend_o[g] = 1'b0;
         assign busy_o[g] = 1'b0;
      end
   end

endmodule

// File: rtl/irq_ctx_select.sv
module irq_ctx_select #(
   parameter int NUM_ID = 32,
   parameter int PW     = 3,
   parameter int IDW    = 5
) (
   input  logic [NUM_ID-1:0]    cand_i,
   input  logic [NUM_ID*PW-1:0] prio_i,
   input  logic [PW-1:0]        thr_i,
   output logic [IDW-1:0]       id_o,
   output logic                 irq_o
);

   logic [PW-1:0]  best_p;
   logic [IDW-1:0] best_id;
   logic           unused_low;

   assign unused_low = ^{cand_i[0], prio_i[PW-1:0]};

   // Ascending scan with a strict compare: the smaller ID keeps a tie,
   // and starting from the threshold enforces "strictly above"
   always_comb begin
      best_p  = thr_i;
      best_id = '0;
      for (int i = 1; i < NUM_ID; i++) begin
         if (cand_i[i] && (prio_i[i*PW +: PW] > best_p)) begin
            best_p  = prio_i[i*PW +: PW];
            best_id = IDW'(i);
         end
      end
   end

   assign id_o  = best_id;
   assign irq_o = (best_id != '0);

endmodule

// File: rtl/prio_irq_router.sv
module prio_irq_router
   import irq_router_pkg::*;
#(
   parameter int NUM_SRC = 31,
   parameter int NUM_CTX = 2,
   parameter int PRIO_W  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC:1]   src_i,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_re,
   input  logic               bus_we,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic [NUM_CTX-1:0] irq_o
);

   localparam int NUM_ID = NUM_SRC + 1;
   localparam int NWORD  = (NUM_ID + 31) / 32;
   localparam int NPAD   = NWORD * 32;
   localparam int IDW    = $clog2(NUM_ID);
   localparam int CTXW   = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;
   localparam int WDW    = (NWORD > 1) ? $clog2(NWORD) : 1;
   localparam int WA_W   = ADDR_W - 2;

   localparam logic [WA_W-1:0] W_PRIO_LAST = WA_W'(NUM_SRC);
   localparam logic [WA_W-1:0] W_PEND      = WA_W'(PEND_WBASE);
   localparam logic [WA_W-1:0] W_PEND_LAST = WA_W'(PEND_WBASE + NWORD - 1);
   localparam logic [WA_W-1:0] W_EN        = WA_W'(EN_WBASE);
   localparam logic [WA_W-1:0] W_EN_LAST   = WA_W'(EN_WBASE + EN_WSTRIDE*NUM_CTX - 1);
   localparam logic [WA_W-1:0] W_CTX       = WA_W'(CTX_WBASE);
   localparam logic [WA_W-1:0] W_CTX_LAST  = WA_W'(CTX_WBASE + CTX_WSTRIDE*NUM_CTX - 1);

   // Bits that stand for implemented sources (ID 0 and padding excluded)
   localparam logic [NPAD-1:0] IMPL_MASK = ((NPAD'(1) << NUM_ID) - NPAD'(1)) & ~NPAD'(1);

   initial begin
      if (NUM_SRC < 1 || NUM_SRC > MAX_SRC)
         $error("prio_irq_router: NUM_SRC %0d outside 1..%0d", NUM_SRC, MAX_SRC);
      if (NUM_CTX < 1 || NUM_CTX > MAX_CTX)
         $error("prio_irq_router: NUM_CTX %0d outside 1..%0d", NUM_CTX, MAX_CTX);
      if (PRIO_W < 1 || PRIO_W > DATA_W)
         $error("prio_irq_router: PRIO_W %0d outside 1..%0d", PRIO_W, DATA_W);
   end

   // ---------------- address decode ----------------
   logic [WA_W-1:0] wa;
   logic [WA_W-1:0] off_p;
   logic [WA_W-1:0] off_e;
   logic [WA_W-1:0] off_c;
   reg_kind_e       kind;
   logic [IDW-1:0]  d_id;
   logic [WDW-1:0]  d_wd;
   logic [CTXW-1:0] d_ctx;

   assign wa    = bus_addr[ADDR_W-1:2];
   assign off_p = wa - W_PEND;
   assign off_e = wa - W_EN;
   assign off_c = wa - W_CTX;

   always_comb begin
      kind  = RG_NONE;
      d_id  = '0;
      d_wd  = '0;
      d_ctx = '0;
      if (wa != '0 && wa <= W_PRIO_LAST) begin
         kind = RG_PRIO;
         d_id = wa[IDW-1:0];
      end else if (wa >= W_PEND && wa <= W_PEND_LAST) begin
         kind = RG_PEND;
         d_wd = off_p[WDW-1:0];
      end else if (wa >= W_EN && wa <= W_EN_LAST &&
                   {1'b0, off_e[4:0]} < 6'(NWORD)) begin
         kind  = RG_EN;
         d_wd  = off_e[WDW-1:0];
         d_ctx = off_e[5 +: CTXW];
      end else if (wa >= W_CTX && wa <= W_CTX_LAST && off_c[9:1] == '0) begin
         kind  = off_c[0] ? RG_CLAIM : RG_THR;
         d_ctx = off_c[10 +: CTXW];
      end
   end

   // ---------------- configuration storage ----------------
   logic [PRIO_W-1:0] prio_q [NUM_ID];
   logic [NPAD-1:0]   en_q   [NUM_CTX];
   logic [PRIO_W-1:0] thr_q  [NUM_CTX];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_ID; i++)  prio_q[i] <= '0;
         for (int c = 0; c < NUM_CTX; c++) begin
            en_q[c]  <= '0;
            thr_q[c] <= '0;
         end
      end else if (bus_we) begin
         case (kind)
            RG_PRIO: prio_q[d_id] <= bus_wdata[PRIO_W-1:0];
            RG_EN:   en_q[d_ctx][{d_wd, 5'b0} +: 32] <=
                        bus_wdata & IMPL_MASK[{d_wd, 5'b0} +: 32];
            RG_THR:  thr_q[d_ctx] <= bus_wdata[PRIO_W-1:0];
            default: ;
         endcase
      end
   end

   logic [NUM_ID*PRIO_W-1:0] prio_flat;
   for (genvar i = 0; i < NUM_ID; i++) begin : g_pflat
      assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
   end

   // ---------------- pending / in-service state ----------------
   logic [NPAD-1:0] pend_vec;
   logic [NPAD-1:0] busy_vec;
   logic [IDW-1:0]  sel_id [NUM_CTX];
   logic            clm_vld;
   logic            cmp_vld;

   assign clm_vld = bus_re && (kind == RG_CLAIM);
   assign cmp_vld = bus_we && (kind == RG_CLAIM) &&
                    (bus_wdata != '0) && (bus_wdata < DATA_W'(NUM_ID));

   irq_src_gate #(
      .NUM_SRC (NUM_SRC),
      .NUM_CTX (NUM_CTX),
      .NPAD    (NPAD),
      .IDW     (IDW),
      .CTXW    (CTXW)
   ) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_i     (src_i),
      .clm_vld_i (clm_vld),
      .clm_id_i  (sel_id[d_ctx]),
      .clm_ctx_i (d_ctx),
      .cmp_vld_i (cmp_vld),
      .cmp_id_i  (bus_wdata[IDW-1:0]),
      .cmp_ctx_i (d_ctx),
      .pend_o    (pend_vec),
      .busy_o    (busy_vec)
   );

   // ---------------- per-context selection ----------------
   for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
      logic [NUM_ID-1:0] cand;
      assign cand = pend_vec[NUM_ID-1:0] & en_q[c][NUM_ID-1:0];

      irq_ctx_select #(
         .NUM_ID (NUM_ID),
         .PW     (PRIO_W),
         .IDW    (IDW)
      ) u_sel (
         .cand_i (cand),
         .prio_i (prio_flat),
         .thr_i  (thr_q[c]),
         .id_o   (sel_id[c]),
         .irq_o  (irq_o[c])
      );
   end

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      if (bus_re) begin
         case (kind)
            RG_PRIO:  bus_rdata = DATA_W'(prio_q[d_id]);
            RG_PEND:  bus_rdata = pend_vec[{d_wd, 5'b0} +: 32];
            RG_EN:    bus_rdata = en_q[d_ctx][{d_wd, 5'b0} +: 32];
            RG_THR:   bus_rdata = DATA_W'(thr_q[d_ctx]);
            RG_CLAIM: bus_rdata = DATA_W'(sel_id[d_ctx]);
            default:  bus_rdata = '0;
         endcase
      end
   end

   logic unused_bits;
   assign unused_bits = ^{bus_addr[1:0], off_p, off_e, off_c, busy_vec};

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
   parameter int NUM_SRC = 31,
   parameter int NUM_CTX = 2,
   parameter int NPAD    = 32,
   parameter int IDW     = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC:1]   src_i,
   input logic [23:0]        bus_addr,
   input logic               bus_re,
   input logic [31:0]        bus_rdata,
   input logic [NUM_CTX-1:0] irq_o,
   input logic [NPAD-1:0]    pend_vec,
   input logic [NPAD-1:0]    busy_vec
);

   logic [NPAD-1:0] src_ext;
   assign src_ext = NPAD'({src_i, 1'b0});

   assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (irq_o == '0));

   assert_slot_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && bus_addr[23:2] == 22'd0) |-> (bus_rdata == 32'd0));

   assert_pend_needs_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_vec & ~$past(pend_vec) & ~$past(src_ext)) == '0);

   assert_pend_busy_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_vec & busy_vec) == '0);

   for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
      localparam logic [23:0] CLAIM_A = 24'(32'h200004 + c * 32'h1000);

      assert_empty_claim_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_re && bus_addr == CLAIM_A && !irq_o[c]) |-> (bus_rdata == 32'd0));

      assert_claim_takes_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_re && bus_addr == CLAIM_A && bus_rdata != 32'd0) |=>
            (busy_vec[$past(bus_rdata[IDW-1:0])] && !pend_vec[$past(bus_rdata[IDW-1:0])]));
   end

endmodule

bind prio_irq_router irq_router_chk #(
   .NUM_SRC (NUM_SRC),
   .NUM_CTX (NUM_CTX),
   .NPAD    (NPAD),
   .IDW     (IDW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .src_i     (src_i),
   .bus_addr  (bus_addr),
   .bus_re    (bus_re),
   .bus_rdata (bus_rdata),
   .irq_o     (irq_o),
   .pend_vec  (pend_vec),
   .busy_vec  (busy_vec)
);

// File: tb/test_prio_irq_router.sv
`timescale 1ns/1ps
module test_prio_irq_router;

   localparam int NS = 31;
   localparam int NC = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS:1]   src = '0;
   logic [23:0]   addr = '0;
   logic          re = 1'b0;
   logic          we = 1'b0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [NC-1:0] irq;

   always #2 clk = ~clk;

   prio_irq_router #(.NUM_SRC(NS), .NUM_CTX(NC), .PRIO_W(3)) i_prio_irq_router (
      .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(addr), .bus_re(re),
      .bus_we(we), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 0;
   logic [31:0] last_rd;

   // ---------------- reference model ----------------
   logic [2:0]  m_prio [32];
   logic [31:0] m_en   [NC];
   logic [2:0]  m_thr  [NC];
   logic [31:0] m_pend;
   logic [31:0] m_busy;
   int          m_own  [32];

   function automatic logic [23:0] a_prio(int id); return 24'(4*id); endfunction
   function automatic logic [23:0] a_pend(int k); return 24'('h1000 + 4*k); endfunction
   function automatic logic [23:0] a_en(int c); return 24'('h2000 + 'h80*c); endfunction
   function automatic logic [23:0] a_thr(int c); return 24'('h200000 + 'h1000*c); endfunction
   function automatic logic [23:0] a_clm(int c); return 24'('h200004 + 'h1000*c); endfunction

   function automatic int m_sel(int c);
      int best = 0;
      logic [2:0] bp = m_thr[c];
      for (int id = 1; id <= NS; id++)
         if (m_pend[id] && m_en[c][id] && m_prio[id] > bp) begin
            bp = m_prio[id];
            best = id;
         end
      return best;
   endfunction

   function automatic logic [31:0] m_read(logic [23:0] a);
      logic [23:0] w = a & 24'hFFFFFC;
      if (w >= 24'd4 && w <= 24'(4*NS)) return 32'(m_prio[w[23:2]]);
      if (w == a_pend(0)) return m_pend;
      for (int c = 0; c < NC; c++) begin
         if (w == a_en(c))  return m_en[c];
         if (w == a_thr(c)) return 32'(m_thr[c]);
         if (w == a_clm(c)) return 32'(m_sel(c));
      end
      return 32'd0;
   endfunction

   function automatic string req_of(logic [23:0] a);
      logic [23:0] w = a & 24'hFFFFFC;
      if (w >= 24'd4 && w <= 24'(4*NS)) return "R2";
      if (w == a_pend(0)) return "R3";
      for (int c = 0; c < NC; c++) begin
         if (w == a_en(c))  return "R4";
         if (w == a_thr(c)) return "R5";
         if (w == a_clm(c)) return "R7";
      end
      return "R10";
   endfunction

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic m_reset();
      for (int i = 0; i < 32; i++) begin m_prio[i] = '0; m_own[i] = 0; end
      for (int c = 0; c < NC; c++) begin m_en[c] = '0; m_thr[c] = '0; end
      m_pend = '0;
      m_busy = '0;
   endtask

   // One bus cycle: drive at negedge, check outputs, then apply edge to model
   task automatic op(bit r, bit w, logic [23:0] a, logic [31:0] d);
      logic [31:0] srcv;
      logic [31:0] np;
      int s [NC];
      logic [23:0] wa;
      @(negedge clk);
      re = r; we = w; addr = a; wdata = d;
      #1;
      for (int c = 0; c < NC; c++)
         check("R6", $sformatf("irq[%0d]", c), 32'(irq[c]), 32'(m_sel(c) != 0));
      if (r) begin
         last_rd = rdata;
         check(req_of(a), $sformatf("read @%h", a), rdata, m_read(a));
      end else begin
         check("R10", "idle rdata", rdata, 32'd0);
      end
      for (int c = 0; c < NC; c++) s[c] = m_sel(c);
      srcv = {src, 1'b0};
      wa = a & 24'hFFFFFC;
      @(posedge clk);
      #1;
      np = m_pend | (srcv & ~m_busy);
      if (r)
         for (int c = 0; c < NC; c++)
            if (wa == a_clm(c) && s[c] != 0) begin
               np[s[c]] = 1'b0;
               m_busy[s[c]] = 1'b1;
               m_own[s[c]] = c;
            end
      if (w) begin
         if (wa >= 24'd4 && wa <= 24'(4*NS)) m_prio[wa[23:2]] = d[2:0];
         for (int c = 0; c < NC; c++) begin
            if (wa == a_en(c))  m_en[c] = d & 32'hFFFFFFFE;
            if (wa == a_thr(c)) m_thr[c] = d[2:0];
            if (wa == a_clm(c) && d >= 1 && d <= NS)
               if (m_busy[d] && m_own[d] == c) m_busy[d] = 1'b0;
         end
      end
      m_pend = np & 32'hFFFFFFFE;
      re = 0; we = 0;
   endtask

   task automatic rd(logic [23:0] a); op(1, 0, a, 32'd0); endtask
   task automatic wr(logic [23:0] a, logic [31:0] d); op(0, 1, a, d); endtask
   task automatic idle(); op(0, 0, 24'd0, 32'd0); endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         finish_run();
      end
   end

   initial begin
      int unsigned seed;
      logic [31:0] lastc [NC];
      seed = $urandom(32'd20170804);
      m_reset();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state
      #1;
      check("R1", "irq after reset", 32'(irq), 32'd0);
      rd(a_clm(0)); check("R1", "claim ctx0 after reset", last_rd, 32'd0);
      rd(a_clm(1)); check("R1", "claim ctx1 after reset", last_rd, 32'd0);
      rd(a_pend(0)); check("R1", "pending after reset", last_rd, 32'd0);

      // R2: priority width and slot 0
      wr(a_prio(7), 32'hFFFFFFFF);
      rd(a_prio(7)); check("R2", "prio 7 masked", last_rd, 32'd7);
      wr(24'd0, 32'hFFFFFFFF);
      rd(24'd0); check("R2", "slot 0", last_rd, 32'd0);

      // R4: enable bit 0 stuck at zero
      wr(a_en(0), 32'hFFFFFFFF);
      rd(a_en(0)); check("R4", "enable ctx0", last_rd, 32'hFFFFFFFE);

      // R7: equal-priority tie goes to the smaller ID
      wr(a_prio(7), 32'd1);
      wr(a_prio(3), 32'd4);
      wr(a_prio(5), 32'd4);
      src[3] = 1'b1; src[5] = 1'b1;
      idle();
      rd(a_pend(0)); check("R3", "pending 3 and 5", last_rd, 32'h28);
      rd(a_clm(0)); check("R7", "tie winner", last_rd, 32'd3);
      rd(a_clm(0)); check("R7", "second claim", last_rd, 32'd5);
      rd(a_clm(0)); check("R7", "nothing left", last_rd, 32'd0);

      // R8: held inputs do not re-pend while in service
      idle();
      rd(a_pend(0)); check("R8", "no re-pend", last_rd, 32'd0);

      // R9: completion from the wrong context or with a wrong ID is ignored
      wr(a_clm(1), 32'd3);
      wr(a_clm(0), 32'd6);
      idle();
      rd(a_pend(0)); check("R9", "ignored completions", last_rd, 32'd0);
      wr(a_clm(0), 32'd3);
      idle();
      rd(a_pend(0)); check("R9", "3 re-pends after completion", last_rd, 32'h08);
      wr(a_clm(0), 32'd5);
      idle();
      rd(a_pend(0)); check("R9", "5 re-pends after completion", last_rd, 32'h28);
      src[3] = 1'b0; src[5] = 1'b0;
      rd(a_clm(0)); rd(a_clm(0));
      wr(a_clm(0), 32'd3); wr(a_clm(0), 32'd5);

      // R5: priority equal to threshold never interrupts
      wr(a_en(1), 32'h0000_0200);
      wr(a_prio(9), 32'd4);
      wr(a_thr(1), 32'd4);
      src[9] = 1'b1;
      idle(); idle();
      check("R5", "prio == threshold", 32'(irq[1]), 32'd0);
      rd(a_clm(1)); check("R5", "claim at threshold", last_rd, 32'd0);
      wr(a_thr(1), 32'd3);
      check("R6", "prio above threshold", 32'(irq[1]), 32'd1);
      rd(a_clm(1)); check("R7", "ctx1 claims 9", last_rd, 32'd9);
      check("R8", "irq drops after claim", 32'(irq), 32'd0);
      wr(a_clm(1), 32'd9);
      src[9] = 1'b0;

      // R10: reserved offsets
      wr(24'h200008, 32'hFFFFFFFF);
      rd(24'h200008); check("R10", "ctx gap", last_rd, 32'd0);
      wr(24'h1FFFFC, 32'hFFFFFFFF);
      rd(24'h1FFFFC); check("R10", "enable gap", last_rd, 32'd0);
      rd(24'h001004); check("R10", "pending word 1", last_rd, 32'd0);
      rd(24'h0000FC); check("R10", "prio beyond sources", last_rd, 32'd0);
      rd(a_thr(0)); check("R5", "thr ctx0 untouched", last_rd, 32'd0);

      // Randomised phase checked against the model
      for (int c = 0; c < NC; c++) lastc[c] = 0;
      for (int n = 0; n < 6000; n++) begin
         int k = $urandom % 10;
         int c = $urandom % NC;
         if ($urandom % 6 == 0) src = NS'($urandom & $urandom);
         case (k)
            0, 1: wr(a_prio($urandom % 34), $urandom);
            2:    wr(a_en(c), $urandom);
            3:    wr(a_thr(c), $urandom % 4);
            4, 5: begin rd(a_clm(c)); if (last_rd != 0) lastc[c] = last_rd; end
            6:    wr(a_clm(c), ($urandom % 3 == 0) ? 32'($urandom % 40) : lastc[c]);
            7:    rd(a_pend(0));
            8:    rd(24'($urandom % 4) == 0 ? 24'h200008 : a_en(c));
            default: idle();
         endcase
      end

      finish_run();
   end

endmodule